// File: doc/BRIEF.md
# 16-bit Timer/Event Counter with Sticky Overflow Flag

This block is a 16-bit up-counter that advances by one in every clock cycle where its count enable is high. Two capture/compare slots sit next to it. A sticky flag records each wrap from all ones to zero. A control register selects one of three running modes: free-running, restart from zero when the counter reaches the first compare value, or restart from zero on a selected edge of an external trigger. The same register also selects the trigger polarity and decides, for each slot, whether the slot compares or captures.

Software reaches the counter, both slots and the control register through one select/write/read port. The overflow flag is cleared by writing the control register with bit 6 at 0. A clear that arrives after a wrap but before the next count step is dropped. This keeps a wrap that has not yet been seen from being lost.

A capture takes precedence over a software read of the same slot in the same cycle. That read is marked as invalid. A write to the first slot in the cycle where it matches the counter cancels that match and raises a conflict warning.

Top module: `tmr16_core`

## Requirements
- R1: After reset the counter, both slots, the control register and the overflow flag read zero. Mode 00 (control bits [1:0]) holds the counter still even with the count enable high.
- R2: In modes 01 (free-running), 10 (restart on match) and 11 (restart on trigger), the counter adds one in each cycle with the count enable high. It holds its value when the enable is low.
- R3: A count step taken at 16'hFFFF leaves the counter at zero and sets the overflow flag on the same edge. This holds in every running mode, including mode 10 with slot A at 16'hFFFF, where the match interrupt also fires.
- R4: A clear request (control write with bit 6 = 0) made after a wrap and before the next count step is ignored, and the flag stays 1.
- R5: A clear request at any other time drops the flag on the next edge. A control write with bit 6 = 1 never sets the flag.
- R6: With slot A in compare mode (control bit 4 = 0) and a running mode, a counting cycle where the counter equals slot A gives a one-cycle match_irq pulse on the next edge. In mode 10 the counter also goes to zero on that edge.
- R7: In mode 11 a valid trigger edge puts the counter at zero on the next clock edge, in place of the count step.
- R8: Control bits [3:2] select the valid trigger edge: 00 none, 01 rising, 10 falling, 11 both. An edge is a change of trig_in from its value in the previous cycle.
- R9: When capture is enabled for slot A (bit 4) or slot B (bit 5), a valid trigger edge copies the counter value of that cycle into the slot. The capture wins over a software write to the same slot.
- R10: A read (reg_rd high) of a slot in the cycle where that slot captures sets rd_bad and returns 16'hFFFF. The capture still takes place.
- R11: A write to slot A in a cycle where slot A matches the counter cancels that match: there is no interrupt and no restart. wr_conflict pulses for one cycle on the next edge.
- R12: reg_sel selects 0 counter, 1 slot A, 2 slot B, 3 control. Control reads return bits [5:0] as written and the flag in bit 6. A counter write loads the value and overrides counting, restart and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable |
| trig_in | input | 1 | External trigger level |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (used only for the collision mark) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| rd_bad | output | 1 | Current read collides with a capture |
| match_irq | output | 1 | One-cycle match interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |
| wr_conflict | output | 1 | One-cycle warning for a compare write at match |

## Verification
The hardest case to reach is the short window between a wrap and the next count step. The window exists only when a clear request lands in a cycle after the counter has left 16'hFFFF and before it has moved on from zero. The directed part loads the counter just below the top, steps it over, and then holds the enable low while it issues the clear. The random part keeps loading the counter to values near 16'hFFFF and drops the enable often, so the window recurs with clear requests, triggers and slot reads mixed in. A reference model built from the requirements follows every cycle.

// File: rtl/tmr16_pkg.sv
// Package: shared constants for the 16-bit timer.
// Assumes the register select is two bits wide and the control word holds
// six writable bits with the overflow flag shown in bit 6.
package tmr16_pkg;
    localparam logic [1:0] SEL_CNT  = 2'd0;
    localparam logic [1:0] SEL_A    = 2'd1;
    localparam logic [1:0] SEL_B    = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    typedef enum logic [1:0] {
        MODE_STOP  = 2'b00,
        MODE_FREE  = 2'b01,
        MODE_MATCH = 2'b10,
        MODE_TRIG  = 2'b11
    } run_mode_e;

    localparam int CTRL_W      = 6;
    localparam int CTRL_CAP0   = 4;
    localparam int CTRL_OVF    = 6;
    localparam int SLOT_COUNT  = 2;
endpackage

// File: rtl/tmr16_trig_edge.sv
// Module: trigger edge qualifier.
// Registers the trigger level once and flags a valid edge whenever the
// input differs from its last value in the direction(s) picked by edge_sel.
// Assumes trig_in is already synchronous to clk.
module tmr16_trig_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] edge_sel,
    output logic       edge_ok
);
    logic trig_q;
    logic rise;
    logic fall;

    // Remember the previous trigger level.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    // Decide whether the current change is a selected edge.
    always_comb begin
        rise    = trig_in & ~trig_q;
        fall    = ~trig_in & trig_q;
        edge_ok = (edge_sel[0] & rise) | (edge_sel[1] & fall);
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ok |-> (trig_in != trig_q)); // R8
endmodule

// File: rtl/tmr16_ccr_slot.sv
// Module: one capture/compare slot.
// Holds a value that software may write. When capture is enabled, a valid
// trigger edge copies the live counter value in and overrides the write.
module tmr16_ccr_slot #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          edge_ok,
    input  logic [CW-1:0] cnt_val,
    input  logic          wr_en,
    input  logic [CW-1:0] wdata,
    output logic          cap_fire,
    output logic [CW-1:0] val_q
);
    // Capture fires only in capture mode on a qualified edge.
    always_comb cap_fire = cap_en & edge_ok;

    // Update the slot: capture first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        val_q <= '0;
        else if (cap_fire) val_q <= cnt_val;
        else if (wr_en)    val_q <= wdata;
    end

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (val_q == $past(cnt_val))); // R9
endmodule

// File: rtl/tmr16_counter.sv
// Module: counter with sticky overflow flag.
// Priority per cycle: software load, trigger restart, count step. A count
// step at all-ones wraps to zero and sets the flag. A clear request arriving
// after a wrap and before the next step is dropped.
module tmr16_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cnt_en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          trig_clr,
    input  logic          match_clr,
    input  logic          ovf_clr_req,
    output logic [CW-1:0] cnt_q,
    output logic          ovf_q
);
    logic step;
    logic at_top;
    logic wrap;
    logic fresh_q;

    // Derive the count step and the wrap event.
    always_comb begin
        step   = run & cnt_en & ~load & ~trig_clr;
        at_top = (cnt_q == {CW{1'b1}});
        wrap   = step & at_top;
    end

    // Advance, restart or load the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (load)     cnt_q <= load_val;
        else if (trig_clr) cnt_q <= '0;
        else if (step)     cnt_q <= match_clr ? '0 : cnt_q + 1'b1;
    end

    // Mark the span from a wrap up to the next counter change.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fresh_q <= 1'b0;
        else if (wrap)                       fresh_q <= 1'b1;
        else if (step | trig_clr | load)     fresh_q <= 1'b0;
    end

    // Sticky overflow flag with the guarded clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ovf_q <= 1'b0;
        else if (wrap)                      ovf_q <= 1'b1;
        else if (ovf_clr_req & ~fresh_q)    ovf_q <= 1'b0;
    end

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (ovf_q && cnt_q == '0)); // R3
    AST_EARLY_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_q && ovf_clr_req) |=> ovf_q); // R4
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !match_clr && !at_top) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && cnt_en) && !load && !trig_clr) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/tmr16_core.sv
// Module: 16-bit timer/event counter top.
// Ties the control register, trigger qualifier, counter and two slots
// together and provides the register port, match interrupt and warnings.
// Assumes all inputs are synchronous to clk; reg_rdata is combinational.
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int          CW       = 16,
    parameter logic [15:0] BAD_READ = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          trig_in,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    output logic          rd_bad,
    output logic          match_irq,
    output logic          ovf_flag,
    output logic          wr_conflict
);
    localparam int PAD_W = CW - CTRL_W - 1;

    logic [CTRL_W-1:0]  ctrl_q;
    run_mode_e          mode;
    logic               run;
    logic               edge_ok;
    logic [CW-1:0]      cnt_val;
    logic [CW-1:0]      slot_val  [SLOT_COUNT];
    logic [SLOT_COUNT-1:0] slot_cap;
    logic               match_raw;
    logic               conflict;
    logic               hit;
    logic               trig_clr;
    logic               cnt_load;
    logic               clr_req;

    // Decode mode and the register-port strobes.
    always_comb begin
        mode      = run_mode_e'(ctrl_q[1:0]);
        run       = (mode != MODE_STOP);
        cnt_load  = reg_wr & (reg_sel == SEL_CNT);
        clr_req   = reg_wr & (reg_sel == SEL_CTRL) & ~reg_wdata[CTRL_OVF];
        trig_clr  = (mode == MODE_TRIG) & edge_ok;
        match_raw = run & cnt_en & ~ctrl_q[CTRL_CAP0] & (cnt_val == slot_val[0]);
        conflict  = match_raw & reg_wr & (reg_sel == SEL_A);
        hit       = match_raw & ~conflict;
    end

    // Control register holds mode, edge select and capture enables.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (reg_wr && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    // Register the match interrupt and the write-conflict warning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_irq   <= 1'b0;
            wr_conflict <= 1'b0;
        end else begin
            match_irq   <= hit;
            wr_conflict <= conflict;
        end
    end

    tmr16_trig_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .edge_sel (ctrl_q[3:2]),
        .edge_ok  (edge_ok)
    );

    tmr16_counter #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cnt_en      (cnt_en),
        .load        (cnt_load),
        .load_val    (reg_wdata),
        .trig_clr    (trig_clr),
        .match_clr   ((mode == MODE_MATCH) & hit),
        .ovf_clr_req (clr_req),
        .cnt_q       (cnt_val),
        .ovf_q       (ovf_flag)
    );

    // One slot per capture/compare register; slot i listens to bit CAP0+i.
    for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
        tmr16_ccr_slot #(.CW(CW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (ctrl_q[CTRL_CAP0+i]),
            .edge_ok  (edge_ok),
            .cnt_val  (cnt_val),
            .wr_en    (reg_wr && reg_sel == 2'(i + 1)),
            .wdata    (reg_wdata),
            .cap_fire (slot_cap[i]),
            .val_q    (slot_val[i])
        );
    end

    // Read multiplexer with capture-collision marking.
    always_comb begin
        rd_bad = reg_rd & (((reg_sel == SEL_A) & slot_cap[0]) |
                           ((reg_sel == SEL_B) & slot_cap[1]));
        unique case (reg_sel)
            SEL_CNT: reg_rdata = cnt_val;
            SEL_A:   reg_rdata = slot_val[0];
            SEL_B:   reg_rdata = slot_val[1];
            default: reg_rdata = {{PAD_W{1'b0}}, ovf_flag, ctrl_q};
        endcase
        if (rd_bad) reg_rdata = BAD_READ[CW-1:0];
    end

    AST_CONFLICT_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_conflict |-> !match_irq); // R11
    AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MATCH && hit && !cnt_load) |=> (cnt_val == '0 && match_irq)); // R6
    AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_clr && !cnt_load) |=> (cnt_val == '0)); // R7
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP && !cnt_load) |=> $stable(cnt_val)); // R1
    AST_RD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bad |-> (reg_rdata == BAD_READ[CW-1:0])); // R10
endmodule

// File: tb/tmr16_core_tb.sv
`timescale 1ns/1ps
module tmr16_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        trig_in = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        rd_bad, match_irq, ovf_flag, wr_conflict;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Reference state
    logic [15:0] m_cnt, m_a, m_b;
    logic [5:0]  m_ctrl;
    logic        m_ovf, m_fresh, m_trig, m_irq, m_conf;

    always #2 clk = ~clk;

    tmr16_core dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig_in(trig_in),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_bad(rd_bad),
        .match_irq(match_irq), .ovf_flag(ovf_flag), .wr_conflict(wr_conflict)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_edge(logic trg);
        return (m_ctrl[2] & trg & ~m_trig) | (m_ctrl[3] & ~trg & m_trig);
    endfunction

    function automatic logic model_rd_bad(logic [1:0] s, logic rd, logic trg);
        logic e = model_edge(trg);
        return rd & (((s == 2'd1) & m_ctrl[4] & e) | ((s == 2'd2) & m_ctrl[5] & e));
    endfunction

    function automatic logic [15:0] model_rdata(logic [1:0] s, logic rd, logic trg);
        if (model_rd_bad(s, rd, trg)) return 16'hFFFF;
        case (s)
            2'd0:    return m_cnt;
            2'd1:    return m_a;
            2'd2:    return m_b;
            default: return {9'd0, m_ovf, m_ctrl};
        endcase
    endfunction

    function automatic string sel_tag(logic [1:0] s);
        case (s)
            2'd0:    return "R2 counter read";
            2'd1:    return "R9 slot A read";
            2'd2:    return "R9 slot B read";
            default: return "R12 control read";
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_a = 0; m_b = 0; m_ctrl = 0;
        m_ovf = 0; m_fresh = 0; m_trig = 0; m_irq = 0; m_conf = 0;
    endtask

    // Next reference state, written from the requirements.
    task automatic model_step();
        logic run, e, match, conf, good, tclr, load, step, wrap, clr;
        run   = m_ctrl[1:0] != 2'b00;
        e     = model_edge(trig_in);
        match = run & cnt_en & ~m_ctrl[4] & (m_cnt == m_a);
        conf  = match & reg_wr & (reg_sel == 2'd1);
        good  = match & ~conf;
        tclr  = (m_ctrl[1:0] == 2'b11) & e;
        load  = reg_wr & (reg_sel == 2'd0);
        step  = run & cnt_en & ~load & ~tclr;
        wrap  = step & (m_cnt == 16'hFFFF);
        clr   = reg_wr & (reg_sel == 2'd3) & ~reg_wdata[6];
        if (wrap) m_ovf = 1'b1;
        else if (clr & ~m_fresh) m_ovf = 1'b0;
        if (wrap) m_fresh = 1'b1;
        else if (step | tclr | load) m_fresh = 1'b0;
        if (m_ctrl[4] & e) m_a = m_cnt;
        else if (reg_wr & reg_sel == 2'd1) m_a = reg_wdata;
        if (m_ctrl[5] & e) m_b = m_cnt;
        else if (reg_wr & reg_sel == 2'd2) m_b = reg_wdata;
        if (load) m_cnt = reg_wdata;
        else if (tclr) m_cnt = 16'h0;
        else if (step) m_cnt = ((m_ctrl[1:0] == 2'b10) & good) ? 16'h0 : m_cnt + 16'h1;
        if (reg_wr & reg_sel == 2'd3) m_ctrl = reg_wdata[5:0];
        m_irq  = good;
        m_conf = conf;
        m_trig = trig_in;
    endtask

    // One clock with full comparison against the reference.
    task automatic tick(logic en, logic trg, logic [1:0] s, logic wr, logic rd, logic [15:0] wd);
        cnt_en = en; trig_in = trg; reg_sel = s; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
        #1;
        check(sel_tag(s), reg_rdata, model_rdata(s, rd, trg));
        check("R10 rd_bad", {15'd0, rd_bad}, {15'd0, model_rd_bad(s, rd, trg)});
        check("R6 match_irq", {15'd0, match_irq}, {15'd0, m_irq});
        check("R3 ovf_flag", {15'd0, ovf_flag}, {15'd0, m_ovf});
        check("R11 wr_conflict", {15'd0, wr_conflict}, {15'd0, m_conf});
        model_step();
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    // Look at one register without clocking.
    task automatic peek(logic [1:0] s, string tag, logic [15:0] exp);
        reg_sel = s; reg_wr = 1'b0; reg_rd = 1'b0;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        tick(1'b0, trig_in, s, 1'b1, 1'b0, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values and stopped mode
        peek(2'd0, "R1 counter zero", 16'h0);
        peek(2'd1, "R1 slot A zero", 16'h0);
        peek(2'd2, "R1 slot B zero", 16'h0);
        peek(2'd3, "R1 control zero", 16'h0);
        repeat (3) tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        peek(2'd0, "R1 stopped counter", 16'h0);

        // R3/R4/R5 wrap and the guarded clear, free-running
        wr(2'd3, 16'h0001);
        wr(2'd0, 16'hFFFE);
        tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        peek(2'd0, "R2 counted to top", 16'hFFFF);
        tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        peek(2'd0, "R3 wrapped to zero", 16'h0);
        check("R3 flag set on wrap", {15'd0, ovf_flag}, 16'h1);
        wr(2'd3, 16'h0001);
        check("R4 early clear ignored", {15'd0, ovf_flag}, 16'h1);
        tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        wr(2'd3, 16'h0041);
        check("R5 bit6=1 keeps flag", {15'd0, ovf_flag}, 16'h1);
        wr(2'd3, 16'h0001);
        check("R5 later clear works", {15'd0, ovf_flag}, 16'h0);
        wr(2'd3, 16'h0041);
        check("R5 bit6=1 does not set", {15'd0, ovf_flag}, 16'h0);

        // R6 restart on match
        wr(2'd3, 16'h0002);
        wr(2'd1, 16'h0005);
        wr(2'd0, 16'h0004);
        tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        check("R6 irq pulse", {15'd0, match_irq}, 16'h1);
        peek(2'd0, "R6 restarted", 16'h0);
        tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        check("R6 irq one cycle", {15'd0, match_irq}, 16'h0);

        // R3 match at all-ones
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'hFFFF);
        tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        check("R3 flag on match wrap", {15'd0, ovf_flag}, 16'h1);
        check("R3 irq on match wrap", {15'd0, match_irq}, 16'h1);

        // R11 compare write at match
        wr(2'd1, 16'h000A);
        wr(2'd0, 16'h000A);
        tick(1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 16'h0020);
        check("R11 conflict flagged", {15'd0, wr_conflict}, 16'h1);
        check("R11 no irq", {15'd0, match_irq}, 16'h0);
        peek(2'd0, "R11 no restart", 16'h000B);

        // R7/R8 trigger restart, rising only
        wr(2'd3, 16'h0007);
        wr(2'd0, 16'h0100);
        tick(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0);
        peek(2'd0, "R7 trigger restart", 16'h0);
        tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
        peek(2'd0, "R8 falling ignored", 16'h0001);

        // R9/R10 capture into slot A on both edges with a colliding read
        wr(2'd3, 16'h001D);
        wr(2'd0, 16'h0300);
        tick(1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 16'h0);
        peek(2'd1, "R9 captured value", 16'h0300);
        tick(1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 16'h0);
        peek(2'd1, "R10 capture still done", 16'h0301);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic en, trg, w, rd;
            logic [1:0] s;
            logic [15:0] d;
            en  = ($urandom % 6) != 0;
            trg = (($urandom % 5) == 0) ? ~trig_in : trig_in;
            s   = 2'($urandom % 4);
            w   = ($urandom % 8) == 0;
            rd  = 1'($urandom);
            d   = 16'($urandom);
            if (s == 2'd0) d = 16'hFFF8 + 16'($urandom % 8);
            if (s == 2'd1 && ($urandom % 2) == 0) d = m_cnt + 16'($urandom % 4);
            if (s == 2'd3 && d[1:0] == 2'b00) d[0] = 1'b1;
            tick(en, trg, s, w, rd, d);
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule